// File: doc/BRIEF.md
# Watchdog Timer with Match Event Outputs

This block is a supervision counter. Once software arms it, it counts one step per clock cycle toward a programmable limit. If software does not write a fixed key to the refresh register before the count reaches the limit, the block raises a reset request toward the system's clock and reset unit. Reaching the limit is the fault case. A correctly written refresh clears the count and counting starts again.

There is no interrupt line. Two compare registers are checked against the running count instead. Each one drives its own event output with a one-cycle pulse when the count first lands on its value. Software can use these pulses as early warnings, or as timed events on the way to the limit. All configuration goes through a single write port and a combinational read port.

Top module: `wdog_match_timer`

## Requirements
- R1: After reset the request and both event outputs are low and the count reads 0. The control register reads 0. The limit and both compare registers read all ones.
- R2: While not armed, the count stays at 0 and no reset request or event pulse appears, whatever the limit and compare values are.
- R3: A write of 1 in bit 0 to the control register (address 0) arms the block. In the first cycle after that write the count reads 0, and it then rises by one per cycle.
- R4: Once armed, the block stays armed until `rst_n` is asserted. Writing 0 to the control register does not stop counting, and the control register keeps reading 1.
- R5: When the count reaches the limit (address 1), the count holds at that value. One cycle later `rst_req` goes high and stays high until `rst_n`. Refresh writes made after that point are ignored.
- R6: A write of `KICK_KEY` to the refresh register (address 2) while armed clears the count to 0, and counting resumes in the next cycle. A refresh written while the count equals the limit prevents the request.
- R7: A write of any value other than `KICK_KEY` to the refresh register leaves the count running unchanged.
- R8: `evt0` (compare register at address 3) and `evt1` (compare register at address 4) each pulse high for exactly one cycle when the count takes on a new value equal to their compare value. This includes the value 0 in the first cycle after arming.
- R9: No event pulse occurs if the count did not change. A compare register written to equal a held count produces no pulse, and a refresh at count 0 produces no pulse.
- R10: The read port returns the limit, both compare values and the current count (address 5). The refresh register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | CW | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | CW | Read data for `rd_addr` (combinational) |
| rst_req | output | 1 | Sticky reset request |
| evt0 | output | 1 | Compare 0 event pulse |
| evt1 | output | 1 | Compare 1 event pulse |

## Verification
A count register stuck or stepping wrongly shows up at once on the count read-back. It also shifts the cycle in which `rst_req` rises, and that cycle is compared exactly against the limit plus one. A fault in the change-tracking flag shows as a missing, doubled or spurious event pulse in the cycle right after the count moves or stalls. The bench sweeps every limit and compare pair across a small range, so such a fault shows within a few cycles of arming. A lost sticky arm or request bit shows one cycle after the write that should have been ignored.

// File: rtl/wdog_match_timer.sv
module wdog_match_timer #(
  parameter int CW = 16,
  parameter logic [CW-1:0] KICK_KEY = CW'(16'hC35A)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  output logic          rst_req,
  output logic          evt0,
  output logic          evt1
);
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_LIMIT = 3'd1;
  localparam logic [2:0] A_KICK  = 3'd2;
  localparam logic [2:0] A_MAT0  = 3'd3;
  localparam logic [2:0] A_MAT1  = 3'd4;
  localparam logic [2:0] A_COUNT = 3'd5;

  logic          armed, moved;
  logic [CW-1:0] limit, mat0, mat1, cnt, cnt_nx;

  wire arm_wr  = wr_en && wr_addr == A_CTRL && wr_data[0] && !armed;
  wire kick    = wr_en && wr_addr == A_KICK && wr_data == KICK_KEY && armed && !rst_req;
  wire expired = cnt >= limit;

  always_comb begin
    if (!armed || rst_req) cnt_nx = armed ? cnt : '0;
    else if (kick)         cnt_nx = '0;
    else if (expired)      cnt_nx = cnt;
    else                   cnt_nx = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      limit   <= '1;
      mat0    <= '1;
      mat1    <= '1;
      cnt     <= '0;
      moved   <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (arm_wr) armed <= 1'b1;
      if (wr_en && wr_addr == A_LIMIT) limit <= wr_data;
      if (wr_en && wr_addr == A_MAT0)  mat0  <= wr_data;
      if (wr_en && wr_addr == A_MAT1)  mat1  <= wr_data;
      cnt     <= cnt_nx;
      moved   <= arm_wr || (armed && cnt_nx != cnt);
      rst_req <= rst_req || (armed && expired && !kick);
    end
  end

  assign evt0 = moved && cnt == mat0;
  assign evt1 = moved && cnt == mat1;

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {{(CW-1){1'b0}}, armed};
      A_LIMIT: rd_data = limit;
      A_MAT0:  rd_data = mat0;
      A_MAT1:  rd_data = mat1;
      A_COUNT: rd_data = cnt;
      default: rd_data = '0;
    endcase
  end
endmodule

module wdog_match_timer_chk #(
  parameter int CW = 16,
  parameter logic [CW-1:0] KICK_KEY = CW'(16'hC35A)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [CW-1:0] wr_data,
  input logic          rst_req,
  input logic          evt0,
  input logic          evt1,
  input logic          armed,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] limit
);
  wire key_wr = wr_en && wr_addr == 3'd2 && wr_data == KICK_KEY;

  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (cnt == '0 && !rst_req && !evt0 && !evt1));
  a_r4_sticky_arm: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (rst_req && $stable(cnt)));
  a_r5_req_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !rst_req && cnt == limit && !key_wr) |=> rst_req);
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !rst_req && !key_wr && cnt < limit) |=> (cnt == $past(cnt) + 1'b1));
  a_r6_kick: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !rst_req && key_wr) |=> (cnt == '0 && !rst_req));
  a_r8_pulse0: assert property (@(posedge clk) disable iff (!rst_n)
    evt0 |=> !evt0);
  a_r8_pulse1: assert property (@(posedge clk) disable iff (!rst_n)
    evt1 |=> !evt1);
endmodule

bind wdog_match_timer wdog_match_timer_chk #(.CW(CW), .KICK_KEY(KICK_KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rst_req(rst_req), .evt0(evt0), .evt1(evt1), .armed(armed), .cnt(cnt), .limit(limit)
);

// File: tb/wdog_match_timer_test.sv
module wdog_match_timer_test;
  localparam int CW = 16;
  localparam logic [CW-1:0] KEY = 16'hC35A;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = 3'd5;
  logic [CW-1:0] wr_data = '0, rd_data;
  logic rst_req, evt0, evt1;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdog_match_timer #(.CW(CW), .KICK_KEY(KEY)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rst_req(rst_req), .evt0(evt0), .evt1(evt1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [CW-1:0] d);
    rd_addr = a; #1 d = rd_data; rd_addr = 3'd5;
  endtask

  logic [CW-1:0] v;

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 rst_req", rst_req, 0);
    chk("R1 evt0", evt0, 0);
    chk("R1 evt1", evt1, 0);
    chk("R1 count", rd_data, 0);
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd1, v); chk("R1 limit", v, 16'hFFFF);
    rd(3'd3, v); chk("R1 mat0", v, 16'hFFFF);

    // R2 disabled: limit 0, match 0, nothing happens
    wr(3'd1, 0); wr(3'd3, 0); wr(3'd2, KEY);
    for (int i = 0; i < 20; i++) begin
      chk("R2 count", rd_data, 0);
      chk("R2 rst_req", rst_req, 0);
      chk("R2 evt0", evt0, 0);
      @(negedge clk);
    end

    // R10 readback
    wr(3'd1, 16'h1234); wr(3'd3, 16'h0BEE); wr(3'd4, 16'hA0A0);
    rd(3'd1, v); chk("R10 limit", v, 16'h1234);
    rd(3'd3, v); chk("R10 mat0", v, 16'h0BEE);
    rd(3'd4, v); chk("R10 mat1", v, 16'hA0A0);
    rd(3'd2, v); chk("R10 kick reads 0", v, 0);

    // R3 R5 R8 sweep: every limit and match pair in a small range
    for (int t = 0; t <= 5; t++) begin
      for (int m = 0; m <= 6; m++) begin
        do_reset();
        wr(3'd1, CW'(t)); wr(3'd3, CW'(m)); wr(3'd4, CW'((m + 3) % 7));
        wr(3'd0, 1);
        for (int n = 0; n <= t + 3; n++) begin
          chk("R3 count", rd_data, (n < t) ? n : t);
          chk("R5 rst_req", rst_req, (n >= t + 1) ? 1 : 0);
          chk("R8 evt0", evt0, (n <= t && n == m) ? 1 : 0);
          chk("R8 evt1", evt1, (n <= t && n == (m + 3) % 7) ? 1 : 0);
          @(negedge clk);
        end
      end
    end

    // R5 request sticky, later refresh ignored, R9 match written to held count
    wr(3'd2, KEY);
    chk("R5 req held after refresh", rst_req, 1);
    chk("R5 count held", rd_data, 16'd5);
    wr(3'd3, 16'd5);
    chk("R9 no pulse on held count", evt0, 0);

    // R4 sticky arm and R7 wrong key
    do_reset();
    wr(3'd1, 16'd100); wr(3'd0, 1);
    repeat (4) @(negedge clk);
    chk("R3 count 4", rd_data, 4);
    wr(3'd0, 0);
    chk("R4 still counting", rd_data, 5);
    rd(3'd0, v); chk("R4 ctrl reads 1", v, 1);
    wr(3'd2, KEY ^ 16'h0001);
    chk("R7 wrong key ignored", rd_data, 6);
    wr(3'd2, 16'h0000);
    chk("R7 zero key ignored", rd_data, 7);

    // R6 refresh mid-count, then at the limit repeatedly
    wr(3'd2, KEY);
    chk("R6 cleared", rd_data, 0);
    @(negedge clk);
    chk("R6 resumes", rd_data, 1);
    wr(3'd1, 16'd3);
    repeat (1) @(negedge clk);
    chk("R6 at limit", rd_data, 3);
    for (int k = 0; k < 4; k++) begin
      wr(3'd2, KEY);
      chk("R6 cleared at limit", rd_data, 0);
      chk("R6 no request", rst_req, 0);
      repeat (3) @(negedge clk);
      chk("R6 back at limit", rd_data, 3);
    end

    // R9 refresh at count 0 gives no second pulse
    do_reset();
    wr(3'd1, 16'd50); wr(3'd3, 16'd0); wr(3'd0, 1);
    chk("R8 pulse at arm", evt0, 1);
    wr(3'd2, KEY);
    chk("R9 no pulse on refresh at 0", evt0, 0);
    chk("R9 count 0", rd_data, 0);
    @(negedge clk);
    chk("R9 count resumed", rd_data, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule